// File: doc/BRIEF.md
# Saturating Delta Sample Output Stage

This block converts a stream of one-bit delta samples, delivered as whole bytes, into a 7-bit code for a digital-to-analog converter. A byte arrives with a one-cycle valid strobe. It waits in a one-byte holding slot until the serializer is empty. It then moves into an 8-bit serializer that releases one bit per step, least significant bit first. Each released bit moves a 6-bit level up or down by one. The level sticks at its limits instead of wrapping.

The step interval is one eighth of a fetch period, chosen by a 4-bit rate code. Software can also drive the output directly as raw PCM. A direct write loads the level from bits 6:1 and the code's low bit from bit 0. The output code is the level in the upper six bits with that low bit below it. The upstream fetch logic and the converter itself sit outside this block.

Top module: `dmod_out_stage`

## Requirements
- R1: A byte taken in on `byte_valid` waits in a one-byte slot and moves into the serializer whenever the serializer is empty. A byte strobed while the serializer is busy is played after the current one, and its bits are consumed bit 0 first, up to bit 7.
- R2: Steps occur exactly every P clocks, where P is selected by `rate_sel`: code 0→428, 1→380, 2→340, 3→320, 4→286, 5→254, 6→226, 7→214, 8→190, 9→160, 10→142, 11→128, 12→106, 13→84, 14→72, 15→54.
- R3: A released bit of 1 raises the level by one and a bit of 0 lowers it by one, one step per released bit.
- R4: The level saturates: a lowering step at 0 leaves 0, and a raising step at 63 leaves 63.
- R5: `dac_code[6:1]` is the level and `dac_code[0]` is the low bit. The low bit changes only through a direct write, never through a step.
- R6: A direct write (`pcm_we`) makes `dac_code` equal to `pcm_data[6:0]` from the next cycle on. `pcm_data[7]` has no effect.
- R7: Reset clears `dac_code` to 0.
- R8: Once all eight bits of a byte are used and no byte waits, `dac_code` holds its value.
- R9: A direct write in the same cycle as a step wins: the code takes the written value, and that step's bit is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 4 | Step interval selector (R2 table) |
| byte_valid | input | 1 | One-cycle strobe: `byte_data` holds a new sample byte |
| byte_data | input | 8 | Sample byte, bit 0 played first |
| pcm_we | input | 1 | Direct write strobe |
| pcm_data | input | 8 | Direct write value; bits 6:1 to level, bit 0 to low bit |
| dac_code | output | 7 | Converter code {level, low bit} |

## Verification
The hardest case to reach from the ports is a direct write that lands in the exact cycle of a step. The step timer is free-running and is not visible outside the block. The stimulus first plays a byte of ones from a mid level and records the cycle in which the code first moves. It then counts the known step period forward and strobes the direct write one clock before the next step. The written value must appear unchanged, and the remaining six bits must continue from it. The step periods themselves are measured from the spacing of successive code changes at three rate codes, and saturation is reached by preloading the level to its limits with direct writes.

// File: rtl/dmod_pkg.sv
package dmod_pkg;

   localparam int RATE_SEL_W   = 4;
   localparam int MAX_PERIOD   = 428;

   // Clocks between serializer steps (one eighth of the fetch period).
   function automatic int unsigned step_period(input logic [RATE_SEL_W-1:0] sel);
      case (sel)
         4'd0:    step_period = 428;
         4'd1:    step_period = 380;
         4'd2:    step_period = 340;
         4'd3:    step_period = 320;
         4'd4:    step_period = 286;
         4'd5:    step_period = 254;
         4'd6:    step_period = 226;
         4'd7:    step_period = 214;
         4'd8:    step_period = 190;
         4'd9:    step_period = 160;
         4'd10:   step_period = 142;
         4'd11:   step_period = 128;
         4'd12:   step_period = 106;
         4'd13:   step_period = 84;
         4'd14:   step_period = 72;
         default: step_period = 54;
      endcase
   endfunction

endpackage

// File: rtl/dmod_rate_timer.sv
module dmod_rate_timer #(
   parameter int TMR_W = 9
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [dmod_pkg::RATE_SEL_W-1:0]   rate_sel,
   output logic                              tick
);

   localparam int MAX_P = dmod_pkg::MAX_PERIOD;

   if (MAX_P > (1 << TMR_W)) begin : g_bad_width
      $error("dmod_rate_timer: TMR_W too small for the longest period");
   end

   logic [TMR_W-1:0] cnt_q;
   logic [TMR_W-1:0] reload;

   always_comb begin
      reload = TMR_W'(dmod_pkg::step_period(rate_sel) - 1);
   end

   assign tick = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= reload;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/dmod_byte_shifter.sv
module dmod_byte_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              step_en,
   output logic              step_up
);

   localparam int BL_W = $clog2(BYTE_W + 1);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("dmod_byte_shifter: BYTE_W must be at least 2");
   end

   logic [BYTE_W-1:0] pend_q;
   logic              pend_full_q;
   logic [BYTE_W-1:0] sh_q;
   logic [BL_W-1:0]   left_q;
   logic              xfer;

   assign xfer    = (left_q == '0) && pend_full_q;
   assign step_en = tick && (left_q != '0);
   assign step_up = sh_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= '0;
         pend_full_q <= 1'b0;
      end else begin
         pend_full_q <= byte_valid | (pend_full_q & ~xfer);
         if (byte_valid) begin
            pend_q <= byte_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (xfer) begin
         sh_q   <= pend_q;
         left_q <= BL_W'(BYTE_W);
      end else if (step_en) begin
         sh_q   <= sh_q >> 1;
         left_q <= left_q - 1'b1;
      end
   end

endmodule

// File: rtl/dmod_delta_counter.sv
module dmod_delta_counter #(
   parameter int CNT_W  = 6,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              step_up,
   input  logic              load_en,
   input  logic [BYTE_W-1:0] load_data,
   output logic [CNT_W:0]    code
);

   if (BYTE_W < CNT_W + 1) begin : g_bad_load
      $error("dmod_delta_counter: load word narrower than the code");
   end

   logic [CNT_W-1:0] lvl_q;
   logic             lsb_q;
   logic             at_top;
   logic             at_bot;

   assign at_top = &lvl_q;
   assign at_bot = (lvl_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= '0;
         lsb_q <= 1'b0;
      end else if (load_en) begin
         lvl_q <= load_data[CNT_W:1];
         lsb_q <= load_data[0];
      end else if (step_en) begin
         if (step_up && !at_top) begin
            lvl_q <= lvl_q + 1'b1;
         end else if (!step_up && !at_bot) begin
            lvl_q <= lvl_q - 1'b1;
         end
      end
   end

   assign code = {lvl_q, lsb_q};

endmodule

// File: rtl/dmod_out_stage.sv
module dmod_out_stage #(
   parameter int CNT_W  = 6,
   parameter int BYTE_W = 8,
   parameter int TMR_W  = 9
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [dmod_pkg::RATE_SEL_W-1:0]  rate_sel,
   input  logic                             byte_valid,
   input  logic [BYTE_W-1:0]                byte_data,
   input  logic                             pcm_we,
   input  logic [BYTE_W-1:0]                pcm_data,
   output logic [CNT_W:0]                   dac_code
);

   logic tick;
   logic step_en;
   logic step_up;

   dmod_rate_timer #(.TMR_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .tick     (tick)
   );

   dmod_byte_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .step_en    (step_en),
      .step_up    (step_up)
   );

   dmod_delta_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_level (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en   (step_en),
      .step_up   (step_up),
      .load_en   (pcm_we),
      .load_data (pcm_data),
      .code      (dac_code)
   );

endmodule

// File: rtl/dmod_out_stage_chk.sv
module dmod_out_stage_chk #(
   parameter int CNT_W  = 6,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pcm_we,
   input logic [BYTE_W-1:0] pcm_data,
   input logic [CNT_W:0]    dac_code,
   input logic              tick,
   input logic              step_en,
   input logic              step_up
);

   assert_step_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |-> tick);

   assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && step_up && !pcm_we && !(&dac_code[CNT_W:1]))
      |=> dac_code[CNT_W:1] == $past(dac_code[CNT_W:1]) + 1'b1);

   assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !step_up && !pcm_we && dac_code[CNT_W:1] != '0)
      |=> dac_code[CNT_W:1] == $past(dac_code[CNT_W:1]) - 1'b1);

   assert_clip_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && step_up && !pcm_we && (&dac_code[CNT_W:1]))
      |=> (&dac_code[CNT_W:1]));

   assert_clip_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !step_up && !pcm_we && dac_code[CNT_W:1] == '0)
      |=> dac_code[CNT_W:1] == '0);

   assert_lsb_only_by_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pcm_we |=> $stable(dac_code[0]));

   assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_we |=> dac_code == $past(pcm_data[CNT_W:0]));

   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pcm_we && !step_en) |=> $stable(dac_code));

endmodule

bind dmod_out_stage dmod_out_stage_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pcm_we   (pcm_we),
   .pcm_data (pcm_data),
   .dac_code (dac_code),
   .tick     (tick),
   .step_en  (step_en),
   .step_up  (step_up)
);

// File: tb/dmod_out_stage_tb.sv
module dmod_out_stage_tb;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] rate_sel = 4'd15;
   logic       byte_valid = 1'b0;
   logic [7:0] byte_data = '0;
   logic       pcm_we = 1'b0;
   logic [7:0] pcm_data = '0;
   logic [6:0] dac_code;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc++;

   dmod_out_stage u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .rate_sel   (rate_sel),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .pcm_we     (pcm_we),
      .pcm_data   (pcm_data),
      .dac_code   (dac_code)
   );

   function automatic int period_of(input int sel);
      int t[16] = '{428, 380, 340, 320, 286, 254, 226, 214,
                    190, 160, 142, 128, 106, 84, 72, 54};
      return t[sel];
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pcm_write(input logic [7:0] v);
      @(negedge clk);
      pcm_we = 1'b1;
      pcm_data = v;
      @(negedge clk);
      pcm_we = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data = b;
      @(negedge clk);
      byte_valid = 1'b0;
   endtask

   // Play one byte from a preloaded code; compare every observed change.
   task automatic play_byte(input string req, input logic [6:0] start, input logic [7:0] b);
      int p;
      int exp_v[8];
      int n_exp;
      int lvl;
      int k;
      int bad;
      logic [6:0] prev;
      p = period_of(int'(rate_sel));
      lvl = int'(start[6:1]);
      n_exp = 0;
      for (int i = 0; i < 8; i++) begin
         int nx;
         nx = b[i] ? ((lvl == 63) ? 63 : lvl + 1) : ((lvl == 0) ? 0 : lvl - 1);
         if (nx != lvl) begin
            exp_v[n_exp] = nx * 2 + int'(start[0]);
            n_exp++;
         end
         lvl = nx;
      end
      pcm_write({1'b0, start});
      check(req, "preload", int'(dac_code), int'(start));
      prev = dac_code;
      send_byte(b);
      k = 0;
      bad = 0;
      for (int c = 0; c < 9 * p + 4; c++) begin
         if (dac_code != prev) begin
            if (k < n_exp && int'(dac_code) == exp_v[k]) k++;
            else bad++;
            prev = dac_code;
         end
         @(negedge clk);
      end
      check(req, "unexpected steps", bad, 0);
      check(req, "step count", k, n_exp);
      check(req, "final code", int'(dac_code), lvl * 2 + int'(start[0]));
   endtask

   task automatic test_reset;
      check("R7", "reset code", int'(dac_code), 0);
   endtask

   task automatic test_rate(input int sel);
      int p;
      int last_t;
      int n;
      int worst;
      logic [6:0] prev;
      rate_sel = 4'(sel);
      p = period_of(sel);
      repeat (2 * 428 + 4) @(negedge clk);
      pcm_write(8'h40);
      prev = dac_code;
      send_byte(8'hFF);
      n = 0;
      last_t = 0;
      worst = p;
      for (int c = 0; c < 9 * p + 4; c++) begin
         if (dac_code != prev) begin
            if (n > 0 && (cyc - last_t) != p) worst = cyc - last_t;
            last_t = cyc;
            n++;
            prev = dac_code;
         end
         @(negedge clk);
      end
      check("R2", $sformatf("step interval sel %0d", sel), worst, p);
      check("R2", $sformatf("step count sel %0d", sel), n, 8);
   endtask

   task automatic test_hold;
      logic [6:0] v;
      v = dac_code;
      repeat (3 * period_of(int'(rate_sel))) @(negedge clk);
      check("R8", "hold with no byte", int'(dac_code), int'(v));
   endtask

   task automatic test_direct;
      pcm_write(8'hD5);
      check("R6", "bit 7 ignored", int'(dac_code), 8'h55);
      pcm_write(8'h2A);
      check("R6", "direct value", int'(dac_code), 8'h2A);
   endtask

   task automatic test_queue;
      int mx;
      pcm_write(8'h40);
      send_byte(8'hFF);
      send_byte(8'h00);
      mx = 0;
      for (int c = 0; c < 18 * period_of(int'(rate_sel)) + 8; c++) begin
         if (int'(dac_code) > mx) mx = int'(dac_code);
         @(negedge clk);
      end
      check("R1", "queued byte peak", mx, 8'h50);
      check("R1", "queued byte final", int'(dac_code), 8'h40);
   endtask

   task automatic test_collision;
      int p;
      int w;
      logic [6:0] prev;
      p = period_of(int'(rate_sel));
      pcm_write(8'h40);
      prev = dac_code;
      send_byte(8'hFF);
      w = 0;
      while (dac_code == prev && w < 2 * p + 4) begin
         @(negedge clk);
         w++;
      end
      check("R9", "first step seen", int'(dac_code), 8'h42);
      repeat (p - 1) @(negedge clk);
      pcm_we = 1'b1;
      pcm_data = 8'h10;
      @(negedge clk);
      pcm_we = 1'b0;
      check("R9", "write beats step", int'(dac_code), 8'h10);
      repeat (8 * p) @(negedge clk);
      check("R9", "remaining bits", int'(dac_code), 8'h1C);
   endtask

   task automatic test_reset_mid;
      pcm_write(8'h40);
      send_byte(8'hFF);
      repeat (2 * period_of(int'(rate_sel))) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R7", "reset during play", int'(dac_code), 0);
      rst_n = 1'b1;
      repeat (10 * period_of(int'(rate_sel))) @(negedge clk);
      check("R7", "no play after reset", int'(dac_code), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      play_byte("R1", 7'h40, 8'h0F);
      play_byte("R1", 7'h40, 8'hF0);
      play_byte("R3", 7'h41, 8'h01);
      play_byte("R5", 7'h41, 8'hFF);
      play_byte("R4", 7'h7E, 8'hFF);
      play_byte("R4", 7'h01, 8'h00);
      play_byte("R4", 7'h7C, 8'h03);
      test_hold();
      test_direct();
      test_queue();
      test_collision();
      test_rate(15);
      test_rate(7);
      test_rate(0);
      rate_sel = 4'd15;
      repeat (2 * 428 + 4) @(negedge clk);
      test_reset_mid();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule